// File: doc/BRIEF.md
# Double-Buffered Co-processor Bank Wrapper

This block sits around a streaming processing kernel and gives it a uniform face toward the rest of the chip. It has one data port and one control port. The data port reaches eight equal memory banks through a single flat word address. Four of the banks hold kernel input and four hold kernel output. Toward the kernel, the wrapper offers one read-only port onto an input bank and one write-only port onto an output bank. Both ports are steered to the bank pair (input bank k, output bank k) that the kernel currently owns.

Software loads an input bank through the data port and then issues a start command for that pair. It issues a start only once the whole buffer is in place. The wrapper keeps one running job and one queued job. This lets the kernel work on one pair while another pair is filled or drained through the data port, and the next pair starts the cycle after the kernel reports completion. Each pair has a busy flag and a sticky done flag. A start aimed at an occupied pair, or issued while a job is already queued, is refused and latches an error bit.

Top module: `coproc_bank_wrapper`

## Requirements
- R1: Data-port address bits [8:6] select the bank (0 to 3 are input banks 0 to 3, 4 to 7 are output banks 0 to 3) and bits [5:0] select the word. Writes store `ext_wdata`. A read returns the stored word on `ext_rdata` one cycle after the request, and `ext_rdata` holds its value otherwise.
- R2: While pair k is active, `k_rd_data` returns the word of input bank k at `k_rd_addr`, one cycle after the address is presented.
- R3: While pair k is active, `k_wr_en` stores `k_wr_data` into output bank k at `k_wr_addr`. With no active pair, a kernel write changes no memory, which can be seen through a later data-port read.
- R4: A control write to address 0 with bit 0 set is a start for pair `wdata[2:1]`. When no job is running, the next cycle shows a one-cycle `kernel_start` pulse, `kernel_bank` equal to the pair, and that pair's busy flag (status bit k) set.
- R5: A start accepted while another pair runs is queued, with its busy flag set and no `kernel_start`. In the cycle after the running job's `kernel_done`, the queued pair starts with a `kernel_start` pulse. A start that arrives in the same cycle as `kernel_done` with nothing queued begins at once.
- R6: A start is refused when its pair is busy or a job is already queued. A refused start changes no busy flag, gives no `kernel_start`, and sets the error bit (status bit 8).
- R7: `kernel_done` while a job runs clears that pair's busy flag and sets its done flag (status bit 4+k).
- R8: A control write to address 1 clears each done flag whose bit [4+k] is one, and clears the error bit if bit 8 is one. Zero bits have no effect. A set event in the same cycle wins over a clear.
- R9: An accepted start clears the done flag of its pair.
- R10: After reset, all busy and done flags and the error bit read zero, and `kernel_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en | input | 1 | Data-port access request |
| ext_we | input | 1 | Data-port write (1) or read (0) |
| ext_addr | input | 9 | Flat word address: bank in [8:6], word in [5:0] |
| ext_wdata | input | 32 | Data-port write data |
| ext_rdata | output | 32 | Data-port read data, one cycle latency |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_addr | input | 1 | Control register select: 0 command, 1 clear |
| ctl_wdata | input | 32 | Control write data |
| ctl_rdata | output | 32 | Status: busy [3:0], done [7:4], error [8] |
| kernel_start | output | 1 | One-cycle pulse when a pair becomes active |
| kernel_bank | output | 2 | Currently active pair |
| kernel_done | input | 1 | Kernel reports the active job finished |
| k_rd_addr | input | 6 | Kernel read word address |
| k_rd_data | output | 32 | Kernel read data from the active input bank |
| k_wr_en | input | 1 | Kernel write enable |
| k_wr_addr | input | 6 | Kernel write word address |
| k_wr_data | input | 32 | Kernel write data to the active output bank |

## Verification
Some properties are checked on every cycle. At most one owner exists per pair, a queued job always has a running job ahead of it, and a refused start always raises the error bit and never yields a start pulse. An accepted start on an idle wrapper pulses `kernel_start` for the right pair, and completion always marks the finishing pair done. Other behaviour appears only in the bench scenarios: bank routing of both kernel ports, the flat address map, queue promotion after completion, the same-cycle completion-plus-start case, write-one-to-clear with zero bits, and writes being dropped when no pair is active. The bench shows these by comparing every output against a behavioural model on each clock.

// File: rtl/coproc_bank_wrapper.sv
module coproc_bank_wrapper #(
  parameter int DW      = 32,
  parameter int WORD_AW = 6,
  parameter int NB      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ext_en,
  input  logic                        ext_we,
  input  logic [$clog2(NB)+WORD_AW:0] ext_addr,
  input  logic [DW-1:0]               ext_wdata,
  output logic [DW-1:0]               ext_rdata,
  input  logic                        ctl_wr,
  input  logic                        ctl_addr,
  input  logic [31:0]                 ctl_wdata,
  output logic [31:0]                 ctl_rdata,
  output logic                        kernel_start,
  output logic [$clog2(NB)-1:0]       kernel_bank,
  input  logic                        kernel_done,
  input  logic [WORD_AW-1:0]          k_rd_addr,
  output logic [DW-1:0]               k_rd_data,
  input  logic                        k_wr_en,
  input  logic [WORD_AW-1:0]          k_wr_addr,
  input  logic [DW-1:0]               k_wr_data
);
  localparam int BW    = $clog2(NB);
  localparam int NWORD = (2 * NB) << WORD_AW;
  localparam int PADW  = 31 - 2 * NB;

  logic [DW-1:0] mem [NWORD];
  logic          act_v, pend_v, err_f, kst;
  logic [BW-1:0] act_b, pend_b;
  logic [NB-1:0] done_f, busy, done_nx;

  always_comb begin
    busy = '0;
    if (act_v)  busy[act_b]  = 1'b1;
    if (pend_v) busy[pend_b] = 1'b1;
  end

  wire          go    = ctl_wr && !ctl_addr && ctl_wdata[0];
  wire [BW-1:0] go_b  = ctl_wdata[BW:1];
  wire          rej   = go && (busy[go_b] || pend_v);
  wire          acc   = go && !rej;
  wire          fin   = kernel_done && act_v;
  wire          clr   = ctl_wr && ctl_addr;
  wire          free  = !act_v || fin;
  logic         unused_ctl;
  assign unused_ctl = ^ctl_wdata;

  assign ctl_rdata    = {{PADW{1'b0}}, err_f, done_f, busy};
  assign kernel_start = kst;
  assign kernel_bank  = act_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_v <= 1'b0; act_b <= '0; pend_v <= 1'b0; pend_b <= '0; kst <= 1'b0;
    end else begin
      kst <= 1'b0;
      if (fin) begin
        if (pend_v) begin
          act_b <= pend_b; pend_v <= 1'b0; kst <= 1'b1;
        end else act_v <= 1'b0;
      end
      if (acc) begin
        if (free) begin
          act_v <= 1'b1; act_b <= go_b; kst <= 1'b1;
        end else begin
          pend_v <= 1'b1; pend_b <= go_b;
        end
      end
    end
  end

  always_comb begin
    done_nx = done_f;
    if (clr) done_nx = done_nx & ~ctl_wdata[2*NB-1:NB];
    if (acc) done_nx[go_b] = 1'b0;
    if (fin) done_nx[act_b] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_f <= '0; err_f <= 1'b0;
    end else begin
      done_f <= done_nx;
      if (rej) err_f <= 1'b1;
      else if (clr && ctl_wdata[2*NB]) err_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ext_en && ext_we) mem[ext_addr] <= ext_wdata;
    if (k_wr_en && act_v) mem[{1'b1, act_b, k_wr_addr}] <= k_wr_data;
    if (ext_en && !ext_we) ext_rdata <= mem[ext_addr];
    k_rd_data <= mem[{1'b0, act_b, k_rd_addr}];
  end

  a_r5_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    act_v && pend_v |-> act_b != pend_b);
  a_r5_queue_behind_run: assert property (@(posedge clk) disable iff (!rst_n)
    pend_v |-> act_v);
  a_r6_reject_flags_err: assert property (@(posedge clk) disable iff (!rst_n)
    rej |=> ctl_rdata[2*NB]);
  a_r6_reject_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rej && !fin |=> !kernel_start);
  a_r4_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !act_v |=> kernel_start && kernel_bank == $past(go_b));
  a_r7_done_marks: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_f[$past(act_b)]);
endmodule

// File: tb/tb_coproc_bank_wrapper.sv
module tb_coproc_bank_wrapper;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        ext_en = 0, ext_we = 0, ctl_wr = 0, ctl_addr = 0;
  logic        kernel_done = 0, k_wr_en = 0, k_rd_chk = 0;
  logic [8:0]  ext_addr = 0;
  logic [31:0] ext_wdata = 0, ctl_wdata = 0, k_wr_data = 0;
  logic [5:0]  k_rd_addr = 0, k_wr_addr = 0;
  logic [31:0] ext_rdata, ctl_rdata, k_rd_data;
  logic        kernel_start;
  logic [1:0]  kernel_bank;

  coproc_bank_wrapper dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] m_mem [512];
  bit       m_act_v, m_pend_v, m_err, m_kst, m_erd_v, m_krd_v;
  int       m_act_b, m_pend_b;
  bit [3:0] m_done;
  logic [31:0] m_erd, m_krd;
  int       m_erd_a;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act_v = 0; m_pend_v = 0; m_err = 0; m_kst = 0; m_done = 0;
      m_act_b = 0; m_pend_b = 0; m_erd_v = 0; m_krd_v = 0;
    end else begin
      bit go, fin, rej, bsy;
      int sel;
      m_krd_v = k_rd_chk && m_act_v;
      m_krd   = m_mem[m_act_b*64 + k_rd_addr];
      m_erd_v = ext_en && !ext_we;
      if (m_erd_v) begin m_erd = m_mem[ext_addr]; m_erd_a = ext_addr; end
      if (ext_en && ext_we) m_mem[ext_addr] = ext_wdata;
      if (k_wr_en && m_act_v) m_mem[256 + m_act_b*64 + k_wr_addr] = k_wr_data;
      go  = ctl_wr && !ctl_addr && ctl_wdata[0];
      sel = ctl_wdata[2:1];
      fin = kernel_done && m_act_v;
      bsy = (m_act_v && m_act_b == sel) || (m_pend_v && m_pend_b == sel);
      rej = go && (bsy || m_pend_v);
      if (rej) m_err = 1;
      else if (ctl_wr && ctl_addr && ctl_wdata[8]) m_err = 0;
      if (ctl_wr && ctl_addr) m_done = m_done & ~ctl_wdata[7:4];
      m_kst = 0;
      if (fin) begin
        m_done[m_act_b] = 1;
        if (m_pend_v) begin m_act_b = m_pend_b; m_pend_v = 0; m_kst = 1; end
        else m_act_v = 0;
      end
      if (go && !rej) begin
        m_done[sel] = 0;
        if (!m_act_v) begin m_act_v = 1; m_act_b = sel; m_kst = 1; end
        else begin m_pend_v = 1; m_pend_b = sel; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit [3:0] b;
      b = 0;
      if (m_act_v)  b[m_act_b]  = 1;
      if (m_pend_v) b[m_pend_b] = 1;
      chk("R4 busy", {28'h0, ctl_rdata[3:0]}, {28'h0, b});
      chk("R7 done", {28'h0, ctl_rdata[7:4]}, {28'h0, m_done});
      chk("R6 err", {31'h0, ctl_rdata[8]}, {31'h0, m_err});
      chk("R5 kernel_start", {31'h0, kernel_start}, {31'h0, m_kst});
      if (m_kst) chk("R5 kernel_bank", {30'h0, kernel_bank}, m_act_b);
      if (m_erd_v) chk(m_erd_a >= 256 ? "R3 ext_rdata" : "R1 ext_rdata", ext_rdata, m_erd);
      if (m_krd_v) chk("R2 k_rd_data", k_rd_data, m_krd);
    end
  end

  task automatic quiet();
    ext_en = 0; ext_we = 0; ctl_wr = 0; ctl_addr = 0; kernel_done = 0;
    k_wr_en = 0; k_rd_chk = 0;
  endtask
  task automatic step(); @(negedge clk); quiet(); endtask
  task automatic ext_wr(int a, logic [31:0] d);
    step(); ext_en = 1; ext_we = 1; ext_addr = a[8:0]; ext_wdata = d;
  endtask
  task automatic ext_rd(int a);
    step(); ext_en = 1; ext_addr = a[8:0];
  endtask
  task automatic start(int p, bit done_too = 0);
    step(); ctl_wr = 1; ctl_wdata = {29'h0, p[1:0], 1'b1}; kernel_done = done_too;
  endtask
  task automatic clear(logic [31:0] d);
    step(); ctl_wr = 1; ctl_addr = 1; ctl_wdata = d;
  endtask
  task automatic krd(int w);
    step(); k_rd_addr = w[5:0]; k_rd_chk = 1;
  endtask
  task automatic kwr(int w, logic [31:0] d);
    step(); k_wr_en = 1; k_wr_addr = w[5:0]; k_wr_data = d;
  endtask
  task automatic kdone(); step(); kernel_done = 1; endtask
  task automatic flags(string tag, bit [3:0] d, bit e);
    step();
    chk(tag, {23'h0, ctl_rdata[8:4]}, {23'h0, e, d});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int ws[4] = '{0, 1, 37, 63};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 status", ctl_rdata, 32'h0);
    chk("R10 kernel_start", {31'h0, kernel_start}, 32'h0);
    for (int b = 0; b < 8; b++)
      foreach (ws[i]) ext_wr(b*64 + ws[i], 32'hA500_0000 ^ (b << 12) ^ (ws[i] * 77));
    for (int b = 0; b < 8; b++)
      foreach (ws[i]) ext_rd(b*64 + ws[i]);
    start(1); step();
    krd(0); krd(37); krd(63);
    kwr(5, 32'hCAFE_0005); kwr(63, 32'hCAFE_003F);
    start(2);
    start(1);
    start(2);
    start(3);
    flags("R6 refused starts", 4'b0000, 1'b1);
    kdone(); step();
    flags("R7 done after finish", 4'b0010, 1'b1);
    krd(1); krd(63);
    ext_rd(256 + 64 + 5); ext_rd(256 + 64 + 63); ext_rd(256 + 64 + 1);
    clear(32'h0);
    flags("R8 zero clear no effect", 4'b0010, 1'b1);
    clear(32'h0000_0120);
    flags("R8 clear done1 and err", 4'b0000, 1'b0);
    start(0, 1); step();
    kwr(1, 32'h0BAD_0001); krd(0);
    kdone(); step();
    flags("R7 two done", 4'b0101, 1'b0);
    start(2); step();
    flags("R9 start clears done", 4'b0001, 1'b0);
    kdone(); step();
    kwr(37, 32'hDEAD_BEEF); step();
    ext_rd(256 + 128 + 37); ext_rd(256 + 1);
    ext_wr(3*64 + 37, 32'h1234_5678); ext_rd(3*64 + 37);
    step(); step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule